// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This unit sits in the execute stage of a small 8-bit controller core. For every conditional jump it decides whether the branch is taken and forms the next program counter. It also produces the side effects that must be committed in the same step as the decision: a decremented loop count, an updated carry, and a strobe that tells the bit store to clear the tested bit.

The core presents one branch per cycle with `valid_i` high. The inputs are the branch form code, the accumulator, a register operand, a compare byte, the carry flag, the already-selected bit value, the address of the following instruction and a signed 8-bit displacement. All results come from one register stage. Instruction fetch, bit-address decoding and the register writeback itself are handled outside this unit.

Top module: `br_decide_unit`

## Requirements
- R1: Form code 0 (zero test) is taken when `acc_i` is 00h. Form code 1 (non-zero test) is taken when `acc_i` is not 00h.
- R2: Form code 2 (count down) sets `oper_o` to `oper_i` minus one, modulo 256, and is taken when that result is nonzero. An input of 00h therefore gives FFh and the branch is taken.
- R3: Form code 3 (compare) is taken when its first operand differs from `cmp_i`. The first operand is `oper_i` when `cjne_reg_i` is 1 and `acc_i` when it is 0.
- R4: Form code 3 sets `carry_o` to 1 when the first operand is unsigned-less-than `cmp_i`, and to 0 otherwise. Every other form passes `carry_i` through unchanged.
- R5: Form code 4 is taken when `carry_i` is 1. Form code 5 is taken when `carry_i` is 0.
- R6: Form code 6 is taken when `bit_i` is 1. Form code 7 is taken when `bit_i` is 0.
- R7: Form code 8 (test and clear) is taken when `bit_i` is 1. `clr_o` is 1 only when form 8 is taken, and is 0 in every other case.
- R8: When the branch is taken, `next_pc_o` equals `pc_seq_i` plus the sign-extended `disp_i`, modulo 2^16. When it is not taken, `next_pc_o` equals `pc_seq_i`.
- R9: Results appear on the outputs one clock after the cycle in which `valid_i` is high, together with `valid_o`. In a cycle after `valid_i` was low, `taken_o` and `clr_o` are 0.
- R10: While `rst` is high at a clock edge, every output is driven to 0.
- R11: Form codes 9 to 15 are not taken. For them `oper_o` equals `oper_i`, `carry_o` equals `carry_i`, and `clr_o` is 0.
- R12: Every form other than 2 leaves `oper_o` equal to `oper_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | A branch is presented this cycle |
| kind_i | input | 4 | Branch form code |
| cjne_reg_i | input | 1 | Compare form takes its first operand from `oper_i` |
| acc_i | input | 8 | Accumulator |
| oper_i | input | 8 | Register or direct operand |
| cmp_i | input | 8 | Compare byte or immediate |
| carry_i | input | 1 | Current carry flag |
| bit_i | input | 1 | Value of the addressed bit |
| pc_seq_i | input | 16 | Address of the following instruction |
| disp_i | input | 8 | Signed displacement |
| valid_o | output | 1 | Results valid |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 16 | Next program counter |
| oper_o | output | 8 | Updated operand |
| carry_o | output | 1 | Updated carry |
| clr_o | output | 1 | Clear the addressed bit |

## Verification
Every result of this unit (taken, next PC, operand, carry and clear strobe) is due exactly one rising edge after the edge that samples `valid_i` high, with no variation between forms. Each test task drives a branch on a falling edge, waits for the next falling edge, and compares all five outputs there, half a period after the single register stage has loaded. The same timing applies to the tests that drop `valid_i` and to the reset test, so no check ever samples at an edge.

// File: rtl/bdu_pkg.sv
package bdu_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 16;
    localparam int KIND_W = 4;

    typedef enum logic [KIND_W-1:0] {
        BK_ZERO   = 4'd0,
        BK_NZERO  = 4'd1,
        BK_COUNT  = 4'd2,
        BK_CMP    = 4'd3,
        BK_CSET   = 4'd4,
        BK_CCLR   = 4'd5,
        BK_BSET   = 4'd6,
        BK_BCLR   = 4'd7,
        BK_BTCLR  = 4'd8
    } br_kind_e;

    typedef struct packed {
        logic              taken;
        logic [DATA_W-1:0] oper;
        logic              carry;
        logic              clr;
    } br_side_t;

    function automatic logic [ADDR_W-1:0] sext_disp(input logic [DATA_W-1:0] d);
        return {{(ADDR_W-DATA_W){d[DATA_W-1]}}, d};
    endfunction
endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
    import bdu_pkg::*;
(
    input  logic [KIND_W-1:0] kind_i,
    input  logic              cjne_reg_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] oper_i,
    input  logic [DATA_W-1:0] cmp_i,
    input  logic              carry_i,
    input  logic              bit_i,
    output br_side_t          side_o
);
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] dec_val;
    logic [DATA_W-1:0] first_op;

    assign dec_val  = oper_i - ONE;
    assign first_op = cjne_reg_i ? oper_i : acc_i;

    always_comb begin
        side_o.taken = 1'b0;
        side_o.oper  = oper_i;
        side_o.carry = carry_i;
        side_o.clr   = 1'b0;
        case (kind_i)
            BK_ZERO:  side_o.taken = (acc_i == '0);
            BK_NZERO: side_o.taken = (acc_i != '0);
            BK_COUNT: begin
                side_o.oper  = dec_val;
                side_o.taken = (dec_val != '0);
            end
            BK_CMP: begin
                side_o.taken = (first_op != cmp_i);
                side_o.carry = (first_op < cmp_i);
            end
            BK_CSET:  side_o.taken = carry_i;
            BK_CCLR:  side_o.taken = !carry_i;
            BK_BSET:  side_o.taken = bit_i;
            BK_BCLR:  side_o.taken = !bit_i;
            BK_BTCLR: begin
                side_o.taken = bit_i;
                side_o.clr   = bit_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/br_target_calc.sv
module br_target_calc
    import bdu_pkg::*;
(
    input  logic              taken_i,
    input  logic [ADDR_W-1:0] pc_seq_i,
    input  logic [DATA_W-1:0] disp_i,
    output logic [ADDR_W-1:0] next_pc_o
);
    logic [ADDR_W-1:0] jump_pc;

    assign jump_pc   = pc_seq_i + sext_disp(disp_i);
    assign next_pc_o = taken_i ? jump_pc : pc_seq_i;
endmodule

// File: rtl/br_decide_unit.sv
module br_decide_unit
    import bdu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [KIND_W-1:0] kind_i,
    input  logic              cjne_reg_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] oper_i,
    input  logic [DATA_W-1:0] cmp_i,
    input  logic              carry_i,
    input  logic              bit_i,
    input  logic [ADDR_W-1:0] pc_seq_i,
    input  logic [DATA_W-1:0] disp_i,
    output logic              valid_o,
    output logic              taken_o,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic [DATA_W-1:0] oper_o,
    output logic              carry_o,
    output logic              clr_o
);
    br_side_t          side;
    logic [ADDR_W-1:0] tgt;

    br_cond_eval u_eval (
        .kind_i     (kind_i),
        .cjne_reg_i (cjne_reg_i),
        .acc_i      (acc_i),
        .oper_i     (oper_i),
        .cmp_i      (cmp_i),
        .carry_i    (carry_i),
        .bit_i      (bit_i),
        .side_o     (side)
    );

    br_target_calc u_tgt (
        .taken_i   (side.taken),
        .pc_seq_i  (pc_seq_i),
        .disp_i    (disp_i),
        .next_pc_o (tgt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o   <= 1'b0;
            taken_o   <= 1'b0;
            next_pc_o <= '0;
            oper_o    <= '0;
            carry_o   <= 1'b0;
            clr_o     <= 1'b0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) begin
                taken_o   <= side.taken;
                next_pc_o <= tgt;
                oper_o    <= side.oper;
                carry_o   <= side.carry;
                clr_o     <= side.clr;
            end else begin
                taken_o <= 1'b0;
                clr_o   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/br_decide_chk.sv
module br_decide_chk
    import bdu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              valid_i,
    input logic [KIND_W-1:0] kind_i,
    input logic [DATA_W-1:0] oper_i,
    input logic              carry_i,
    input logic [ADDR_W-1:0] pc_seq_i,
    input logic              valid_o,
    input logic              taken_o,
    input logic [ADDR_W-1:0] next_pc_o,
    input logic [DATA_W-1:0] oper_o,
    input logic              carry_o,
    input logic              clr_o
);
    assert_clr_needs_taken_R7: assert property (@(posedge clk) disable iff (rst)
        clr_o |-> (taken_o && $past(kind_i) == BK_BTCLR));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> (!taken_o && !clr_o));

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> valid_o);

    assert_fallthrough_pc_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !taken_o) |-> next_pc_o == $past(pc_seq_i));

    assert_carry_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(kind_i) != BK_CMP) |-> carry_o == $past(carry_i));

    assert_count_taken_R2: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(kind_i) == BK_COUNT) |-> taken_o == (oper_o != '0));

    assert_oper_kept_R12: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(kind_i) != BK_COUNT) |-> oper_o == $past(oper_i));

    assert_unknown_untaken_R11: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(kind_i) > BK_BTCLR) |-> !taken_o);
endmodule

bind br_decide_unit br_decide_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (valid_i),
    .kind_i    (kind_i),
    .oper_i    (oper_i),
    .carry_i   (carry_i),
    .pc_seq_i  (pc_seq_i),
    .valid_o   (valid_o),
    .taken_o   (taken_o),
    .next_pc_o (next_pc_o),
    .oper_o    (oper_o),
    .carry_o   (carry_o),
    .clr_o     (clr_o)
);

// File: tb/sim_br_decide_unit.sv
module sim_br_decide_unit;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [3:0]  kind_i;
    logic        cjne_reg_i;
    logic [7:0]  acc_i, oper_i, cmp_i, disp_i;
    logic        carry_i, bit_i;
    logic [15:0] pc_seq_i;
    logic        valid_o, taken_o, carry_o, clr_o;
    logic [15:0] next_pc_o;
    logic [7:0]  oper_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    br_decide_unit u0 (
        .clk(clk), .rst(rst), .valid_i(valid_i), .kind_i(kind_i),
        .cjne_reg_i(cjne_reg_i), .acc_i(acc_i), .oper_i(oper_i),
        .cmp_i(cmp_i), .carry_i(carry_i), .bit_i(bit_i),
        .pc_seq_i(pc_seq_i), .disp_i(disp_i), .valid_o(valid_o),
        .taken_o(taken_o), .next_pc_o(next_pc_o), .oper_o(oper_o),
        .carry_o(carry_o), .clr_o(clr_o)
    );

    task automatic cmp_val(input string req, input string what,
                           input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic exec(input logic [3:0] k, input logic sel,
                        input logic [7:0] a, input logic [7:0] op,
                        input logic [7:0] c, input logic cy, input logic b,
                        input logic [15:0] pc, input logic [7:0] d,
                        input logic e_tk, input logic [15:0] e_pc,
                        input logic [7:0] e_op, input logic e_cy,
                        input logic e_clr, input string req);
        @(negedge clk);
        valid_i = 1'b1; kind_i = k; cjne_reg_i = sel; acc_i = a;
        oper_i = op; cmp_i = c; carry_i = cy; bit_i = b;
        pc_seq_i = pc; disp_i = d;
        @(negedge clk);
        valid_i = 1'b0;
        cmp_val(req, "valid", {15'd0, valid_o}, 16'd1);
        cmp_val(req, "taken", {15'd0, taken_o}, {15'd0, e_tk});
        cmp_val(req, "next_pc", next_pc_o, e_pc);
        cmp_val(req, "oper", {8'd0, oper_o}, {8'd0, e_op});
        cmp_val(req, "carry", {15'd0, carry_o}, {15'd0, e_cy});
        cmp_val(req, "clr", {15'd0, clr_o}, {15'd0, e_clr});
    endtask

    task automatic t_reset;
        rst = 1'b1; valid_i = 1'b1; kind_i = 4'd8; cjne_reg_i = 1'b0;
        acc_i = 8'h00; oper_i = 8'h55; cmp_i = 8'h00; carry_i = 1'b1;
        bit_i = 1'b1; pc_seq_i = 16'h1234; disp_i = 8'h10;
        repeat (3) @(negedge clk);
        cmp_val("R10", "valid", {15'd0, valid_o}, 16'd0);
        cmp_val("R10", "taken", {15'd0, taken_o}, 16'd0);
        cmp_val("R10", "next_pc", next_pc_o, 16'd0);
        cmp_val("R10", "oper", {8'd0, oper_o}, 16'd0);
        cmp_val("R10", "carry", {15'd0, carry_o}, 16'd0);
        cmp_val("R10", "clr", {15'd0, clr_o}, 16'd0);
        valid_i = 1'b0;
        rst = 1'b0;
    endtask

    task automatic t_zero;   // R1
        exec(4'd0, 0, 8'h00, 8'h11, 8'h00, 0, 0, 16'h1000, 8'h10, 1, 16'h1010, 8'h11, 0, 0, "R1");
        exec(4'd0, 0, 8'h05, 8'h11, 8'h00, 1, 0, 16'h1000, 8'h10, 0, 16'h1000, 8'h11, 1, 0, "R1");
        exec(4'd1, 0, 8'h05, 8'h22, 8'h00, 0, 0, 16'h1000, 8'hF0, 1, 16'h0FF0, 8'h22, 0, 0, "R1");
        exec(4'd1, 0, 8'h00, 8'h22, 8'h00, 0, 0, 16'h1000, 8'hF0, 0, 16'h1000, 8'h22, 0, 0, "R1");
    endtask

    task automatic t_count;  // R2
        exec(4'd2, 0, 8'h00, 8'h05, 8'h00, 1, 0, 16'h2000, 8'h04, 1, 16'h2004, 8'h04, 1, 0, "R2");
        exec(4'd2, 0, 8'h00, 8'h01, 8'h00, 0, 0, 16'h2000, 8'h04, 0, 16'h2000, 8'h00, 0, 0, "R2");
        exec(4'd2, 0, 8'h00, 8'h00, 8'h00, 0, 0, 16'h2000, 8'hFC, 1, 16'h1FFC, 8'hFF, 0, 0, "R2");
    endtask

    task automatic t_compare; // R3 R4
        exec(4'd3, 0, 8'h03, 8'h99, 8'h07, 0, 0, 16'h3000, 8'h08, 1, 16'h3008, 8'h99, 1, 0, "R3");
        exec(4'd3, 0, 8'h07, 8'h99, 8'h07, 1, 0, 16'h3000, 8'h08, 0, 16'h3000, 8'h99, 0, 0, "R4");
        exec(4'd3, 1, 8'h07, 8'h09, 8'h07, 1, 0, 16'h3000, 8'h08, 1, 16'h3008, 8'h09, 0, 0, "R3");
        exec(4'd3, 1, 8'hF0, 8'h80, 8'hFF, 0, 0, 16'h3000, 8'h08, 1, 16'h3008, 8'h80, 1, 0, "R4");
    endtask

    task automatic t_carry;  // R5
        exec(4'd4, 0, 8'h00, 8'h00, 8'h00, 1, 0, 16'h4000, 8'h02, 1, 16'h4002, 8'h00, 1, 0, "R5");
        exec(4'd4, 0, 8'h00, 8'h00, 8'h00, 0, 0, 16'h4000, 8'h02, 0, 16'h4000, 8'h00, 0, 0, "R5");
        exec(4'd5, 0, 8'h00, 8'h00, 8'h00, 0, 0, 16'h4000, 8'h02, 1, 16'h4002, 8'h00, 0, 0, "R5");
        exec(4'd5, 0, 8'h00, 8'h00, 8'h00, 1, 0, 16'h4000, 8'h02, 0, 16'h4000, 8'h00, 1, 0, "R5");
    endtask

    task automatic t_bit;    // R6 R7
        exec(4'd6, 0, 8'h00, 8'h00, 8'h00, 0, 1, 16'h5000, 8'h06, 1, 16'h5006, 8'h00, 0, 0, "R6");
        exec(4'd6, 0, 8'h00, 8'h00, 8'h00, 0, 0, 16'h5000, 8'h06, 0, 16'h5000, 8'h00, 0, 0, "R6");
        exec(4'd7, 0, 8'h00, 8'h00, 8'h00, 0, 0, 16'h5000, 8'h06, 1, 16'h5006, 8'h00, 0, 0, "R6");
        exec(4'd7, 0, 8'h00, 8'h00, 8'h00, 0, 1, 16'h5000, 8'h06, 0, 16'h5000, 8'h00, 0, 0, "R6");
        exec(4'd8, 0, 8'h00, 8'h00, 8'h00, 0, 1, 16'h5000, 8'h06, 1, 16'h5006, 8'h00, 0, 1, "R7");
        exec(4'd8, 0, 8'h00, 8'h00, 8'h00, 0, 0, 16'h5000, 8'h06, 0, 16'h5000, 8'h00, 0, 0, "R7");
        exec(4'd6, 0, 8'h00, 8'h00, 8'h00, 0, 1, 16'h5000, 8'h06, 1, 16'h5006, 8'h00, 0, 0, "R7");
    endtask

    task automatic t_target; // R8
        exec(4'd0, 0, 8'h00, 8'h00, 8'h00, 0, 0, 16'hFFF0, 8'h20, 1, 16'h0010, 8'h00, 0, 0, "R8");
        exec(4'd0, 0, 8'h00, 8'h00, 8'h00, 0, 0, 16'h0005, 8'h80, 1, 16'hFF85, 8'h00, 0, 0, "R8");
        exec(4'd0, 0, 8'h00, 8'h00, 8'h00, 0, 0, 16'h0005, 8'h7F, 1, 16'h0084, 8'h00, 0, 0, "R8");
    endtask

    task automatic t_unknown; // R11 R12
        for (int k = 9; k < 16; k++)
            exec(4'(k), 1, 8'h00, 8'h3C, 8'h77, 1, 1, 16'h6000, 8'h10, 0, 16'h6000, 8'h3C, 1, 0, "R11");
        exec(4'd6, 0, 8'h00, 8'hA5, 8'h00, 0, 1, 16'h6000, 8'h10, 1, 16'h6010, 8'hA5, 0, 0, "R12");
    endtask

    task automatic t_idle;   // R9
        exec(4'd8, 0, 8'h00, 8'h00, 8'h00, 0, 1, 16'h7000, 8'h01, 1, 16'h7001, 8'h00, 0, 1, "R9");
        @(negedge clk);
        cmp_val("R9", "valid idle", {15'd0, valid_o}, 16'd0);
        cmp_val("R9", "taken idle", {15'd0, taken_o}, 16'd0);
        cmp_val("R9", "clr idle", {15'd0, clr_o}, 16'd0);
    endtask

    initial begin
        t_reset();
        t_zero();
        t_count();
        t_compare();
        t_carry();
        t_bit();
        t_target();
        t_unknown();
        t_idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule